// File: doc/BRIEF.md
# Time-Setting Pulse Control FSM

This block turns push-button levels into counting commands for a time-of-day counter. In normal operation it holds a seconds-enable output high, so the counter advances on every tick of the 1 Hz clock. While the set-mode level is high, pressing the hours button or the minutes button gives exactly one increment pulse on the matching output, however long the button is held. The button must be released and pressed again to get another pulse.

The machine has three states. The count state is encoded 00, the minutes-hold state 01 and the hours-hold state 10. The pulse outputs are decoded from the current state and the current inputs, so a pulse appears in the same cycle as the press that causes it. The parameter `SEC_OUT` selects the variant. With `SEC_OUT=1` the block drives the clock-time counter. With `SEC_OUT=0` it drives the alarm-time counter: it never asserts the seconds output and pulses only while its set level is high. Both the buttons and the set level are expected to be debounced already.

Top module: `set_pulse_fsm`

## Requirements
- R1: While `rst` is high all three outputs are low, and in the first cycle after `rst` falls the machine acts from the count state.
- R2: In the count state, with no single-button pattern under set (set_lvl, hr_btn, mn_btn not equal to 1,0,1 or 1,1,0), `inc_s` equals `SEC_OUT` and `inc_h` and `inc_m` are low.
- R3: In the count state the pattern (set_lvl, hr_btn, mn_btn) = (1,0,1) raises `inc_m` in that same cycle and moves the machine to the minutes-hold state.
- R4: In the count state the pattern (1,1,0) raises `inc_h` in that same cycle and moves the machine to the hours-hold state.
- R5: In a hold state, while the pattern that entered it persists, all outputs are low and the state is kept.
- R6: In a hold state with set high, any other pattern drives all outputs low in that cycle and returns the machine to the count state.
- R7: With both buttons high, neither `inc_h` nor `inc_m` is ever raised.
- R8: Every increment pulse lasts one cycle, and a continuous hold of one button gives exactly one pulse.
- R9: With `SEC_OUT=0`, `inc_s` is always low and `inc_h` and `inc_m` behave exactly as with `SEC_OUT=1`.
- R10: Moving straight from one button to the other, with no released cycle between them, gives no pulse in the cycle of the change. If the new button is still held in the next cycle, its pulse comes then.
- R11: Dropping set during a hold gives no pulse and returns the machine to the count state, so `inc_s` follows `SEC_OUT` again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 Hz counting clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_lvl | input | 1 | Set-mode level (time-set or alarm-set) |
| hr_btn | input | 1 | Debounced hours button level |
| mn_btn | input | 1 | Debounced minutes button level |
| inc_h | output | 1 | One-cycle hours increment pulse |
| inc_m | output | 1 | One-cycle minutes increment pulse |
| inc_s | output | 1 | Seconds enable, high in the count state when no press is taken |

## Verification
The directed part covers each kind of press. It tests single presses held for several cycles, which must give exactly one pulse, against a release followed by a new press, which must give a second pulse. It tests a simultaneous two-button press, which must give no pulse, and a direct switch from one button to the other, which tells a real release apart from a change of button. It also tests set dropped during a hold and reset asserted in the middle of a hold. A seeded random phase then holds its inputs for several cycles at a time, so long holds and quick re-presses happen often. Both variants receive the same stimulus, which shows that only the seconds output differs between them.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  localparam int ST_W = 2;
  localparam int PR_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_COUNT = 2'b00,
    ST_MIN   = 2'b01,
    ST_HR    = 2'b10
  } tsp_state_e;

  typedef enum logic [PR_W-1:0] {
    PR_IDLE = 2'd0,
    PR_MIN  = 2'd1,
    PR_HR   = 2'd2,
    PR_BOTH = 2'd3
  } tsp_press_e;

  typedef struct packed {
    logic inc_h;
    logic inc_m;
    logic inc_s;
  } tsp_out_s;

  // Sort the inputs into one press class; nothing counts while set is low.
  function automatic tsp_press_e classify(input logic set_l, input logic hr, input logic mn);
    tsp_press_e pr;
    pr = PR_IDLE;
    if (set_l) begin
      unique case ({hr, mn})
        2'b01:   pr = PR_MIN;
        2'b10:   pr = PR_HR;
        2'b11:   pr = PR_BOTH;
        default: pr = PR_IDLE;
      endcase
    end
    return pr;
  endfunction

  // Work out the next state from the current state and the press class.
  function automatic tsp_state_e step_state(input tsp_state_e cur, input tsp_press_e pr);
    tsp_state_e nx;
    nx = ST_COUNT;
    unique case (cur)
      ST_COUNT: begin
        if (pr == PR_MIN)     nx = ST_MIN;
        else if (pr == PR_HR) nx = ST_HR;
        else                  nx = ST_COUNT;
      end
      ST_MIN:  nx = (pr == PR_MIN) ? ST_MIN : ST_COUNT;
      ST_HR:   nx = (pr == PR_HR)  ? ST_HR  : ST_COUNT;
      default: nx = ST_COUNT;
    endcase
    return nx;
  endfunction

  // Decode the outputs; only the count state can emit anything.
  function automatic tsp_out_s drive_out(input tsp_state_e cur, input tsp_press_e pr,
                                         input logic sec_en);
    tsp_out_s o;
    o = '0;
    if (cur == ST_COUNT) begin
      if (pr == PR_MIN)     o.inc_m = 1'b1;
      else if (pr == PR_HR) o.inc_h = 1'b1;
      else                  o.inc_s = sec_en;
    end
    return o;
  endfunction

endpackage

// File: rtl/tsp_press_decode.sv
module tsp_press_decode
  import tsp_pkg::*;
(
  input  logic       set_lvl,
  input  logic       hr_btn,
  input  logic       mn_btn,
  output tsp_press_e press,
  output logic       both_ev
);

  always_comb begin
    press   = classify(set_lvl, hr_btn, mn_btn);
    both_ev = hr_btn & mn_btn;
  end

endmodule

// File: rtl/tsp_state_reg.sv
module tsp_state_reg
  import tsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  tsp_press_e press,
  output tsp_state_e state_q,
  output logic       hold_kept,
  output logic       enter_ev
);

  tsp_state_e state_d;

  always_comb begin
    state_d   = step_state(state_q, press);
    hold_kept = (state_q != ST_COUNT) && (state_d == state_q);
    enter_ev  = (state_q == ST_COUNT) && (state_d != ST_COUNT);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_COUNT;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/tsp_out_decode.sv
module tsp_out_decode
  import tsp_pkg::*;
#(
  parameter bit SEC_OUT = 1'b1
) (
  input  logic       rst,
  input  tsp_state_e state_q,
  input  tsp_press_e press,
  output logic       inc_h,
  output logic       inc_m,
  output logic       inc_s
);

  tsp_out_s dec;

  always_comb begin
    dec   = drive_out(state_q, press, 1'b1);
    inc_h = dec.inc_h & ~rst;
    inc_m = dec.inc_m & ~rst;
  end

  generate
    if (SEC_OUT) begin : g_sec
      assign inc_s = dec.inc_s & ~rst;
    end else begin : g_nosec
      logic sec_unused;
      assign sec_unused = dec.inc_s;
      assign inc_s = 1'b0 & sec_unused;
    end
  endgenerate

endmodule

// File: rtl/set_pulse_fsm.sv
module set_pulse_fsm
  import tsp_pkg::*;
#(
  parameter bit SEC_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_lvl,
  input  logic hr_btn,
  input  logic mn_btn,
  output logic inc_h,
  output logic inc_m,
  output logic inc_s
);

  tsp_press_e press_cls;
  tsp_state_e state_q;
  logic       both_ev;
  logic       hold_kept;
  logic       enter_ev;

  tsp_press_decode u_dec (
    .set_lvl (set_lvl),
    .hr_btn  (hr_btn),
    .mn_btn  (mn_btn),
    .press   (press_cls),
    .both_ev (both_ev)
  );

  tsp_state_reg u_st (
    .clk       (clk),
    .rst       (rst),
    .press     (press_cls),
    .state_q   (state_q),
    .hold_kept (hold_kept),
    .enter_ev  (enter_ev)
  );

  tsp_out_decode #(.SEC_OUT(SEC_OUT)) u_out (
    .rst     (rst),
    .state_q (state_q),
    .press   (press_cls),
    .inc_h   (inc_h),
    .inc_m   (inc_m),
    .inc_s   (inc_s)
  );

endmodule

// File: rtl/tsp_checker.sv
module tsp_checker
  import tsp_pkg::*;
#(
  parameter bit SEC_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       set_lvl,
  input logic       hr_btn,
  input logic       mn_btn,
  input logic       inc_h,
  input logic       inc_m,
  input logic       inc_s,
  input tsp_state_e st,
  input logic       both_ev,
  input logic       hold_kept,
  input logic       enter_ev
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> (!inc_h && !inc_m && !inc_s));

  assert_count_sec_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT && !set_lvl) |-> (inc_s == SEC_OUT) && !inc_h && !inc_m);

  assert_enter_min_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT && set_lvl && !hr_btn && mn_btn) |-> inc_m ##1 (st == ST_MIN));

  assert_enter_hr_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COUNT && set_lvl && hr_btn && !mn_btn) |-> inc_h ##1 (st == ST_HR));

  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (st != ST_COUNT) |-> (!inc_h && !inc_m && !inc_s));

  assert_hold_keep_R5: assert property (@(posedge clk) disable iff (rst)
    hold_kept |=> (st != ST_COUNT));

  assert_leave_R6: assert property (@(posedge clk) disable iff (rst)
    (st != ST_COUNT && !hold_kept) |=> (st == ST_COUNT));

  assert_both_no_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    both_ev |-> (!inc_h && !inc_m));

  assert_single_m_R8: assert property (@(posedge clk) disable iff (rst)
    inc_m |=> !inc_m);

  assert_single_h_R8: assert property (@(posedge clk) disable iff (rst)
    inc_h |=> !inc_h);

  assert_pulse_enters_R8: assert property (@(posedge clk) disable iff (rst)
    (inc_h || inc_m) |-> enter_ev);

  assert_onehot_out_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inc_h, inc_m, inc_s}) && (SEC_OUT || !inc_s));

  assert_no_set_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (!set_lvl) |-> (!inc_h && !inc_m));

endmodule

bind set_pulse_fsm tsp_checker #(.SEC_OUT(SEC_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .set_lvl   (set_lvl),
  .hr_btn    (hr_btn),
  .mn_btn    (mn_btn),
  .inc_h     (inc_h),
  .inc_m     (inc_m),
  .inc_s     (inc_s),
  .st        (state_q),
  .both_ev   (both_ev),
  .hold_kept (hold_kept),
  .enter_ev  (enter_ev)
);

// File: tb/set_pulse_fsm_tb_top.sv
`timescale 1ns/1ps
module set_pulse_fsm_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_lvl = 1'b0;
  logic hr_btn = 1'b0;
  logic mn_btn = 1'b0;
  logic ch_h, ch_m, ch_s;
  logic al_h, al_m, al_s;

  int checks = 0;
  int errors = 0;
  int ref_st = 0;
  int cnt_h = 0;
  int cnt_m = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  set_pulse_fsm #(.SEC_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .set_lvl(set_lvl), .hr_btn(hr_btn), .mn_btn(mn_btn),
    .inc_h(ch_h), .inc_m(ch_m), .inc_s(ch_s)
  );

  set_pulse_fsm #(.SEC_OUT(1'b0)) dut_alm_i (
    .clk(clk), .rst(rst), .set_lvl(set_lvl), .hr_btn(hr_btn), .mn_btn(mn_btn),
    .inc_h(al_h), .inc_m(al_m), .inc_s(al_s)
  );

  // Reference model, kept as a hold memory: 0 none, 1 minutes, 2 hours.
  function automatic logic [2:0] exp_out(int hold, logic r, logic s, logic h, logic m);
    logic solo_m, solo_h;
    solo_m = s && !h && m;
    solo_h = s && h && !m;
    if (r || hold != 0) return 3'b000;
    if (solo_h) return 3'b100;
    if (solo_m) return 3'b010;
    return 3'b001;
  endfunction

  function automatic int exp_next(int hold, logic r, logic s, logic h, logic m);
    if (r) return 0;
    if (s && !h && m) return (hold == 0 || hold == 1) ? 1 : 0;
    if (s && h && !m) return (hold == 0 || hold == 2) ? 2 : 0;
    return 0;
  endfunction

  function automatic string tag_for(int hold, logic r, logic s, logic h, logic m);
    if (r) return "R1";
    if (hold != 0) begin
      if (!s) return "R11";
      if (hold == 1 && !h && m) return "R5";
      if (hold == 2 && h && !m) return "R5";
      if (hold == 1 && h && !m) return "R10";
      if (hold == 2 && !h && m) return "R10";
      return "R6";
    end
    if (h && m) return "R7";
    if (s && !h && m) return "R3";
    if (s && h && !m) return "R4";
    return "R2";
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic chk_int(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(logic r, logic s, logic h, logic m);
    logic [2:0] e;
    string t;
    @(negedge clk);
    rst = r; set_lvl = s; hr_btn = h; mn_btn = m;
    #1;
    e = exp_out(ref_st, r, s, h, m);
    t = tag_for(ref_st, r, s, h, m);
    chk(t, "inc_h", ch_h, e[2]);
    chk(t, "inc_m", ch_m, e[1]);
    chk(t, "inc_s", ch_s, e[0]);
    chk("R9", "alarm inc_h", al_h, e[2]);
    chk("R9", "alarm inc_m", al_m, e[1]);
    chk("R9", "alarm inc_s", al_s, 1'b0);
    if (ch_h === 1'b1) cnt_h++;
    if (ch_m === 1'b1) cnt_m++;
    ref_st = exp_next(ref_st, r, s, h, m);
    @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset with buttons pressed stays quiet
    step(1, 1, 0, 1);
    step(1, 1, 1, 0);
    // R2: normal counting
    repeat (3) step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    // R3, R5, R8: one pulse across a long minutes hold
    cnt_m = 0;
    repeat (6) step(0, 1, 0, 1);
    chk_int("R8", "minute pulses per hold", cnt_m, 1);
    step(0, 1, 0, 0);            // R6 release
    cnt_m = 0;
    repeat (3) step(0, 1, 0, 1); // R8 re-press
    chk_int("R8", "minute pulses after re-press", cnt_m, 1);
    step(0, 1, 0, 0);
    // R4: hours
    cnt_h = 0;
    repeat (5) step(0, 1, 1, 0);
    chk_int("R4", "hour pulses per hold", cnt_h, 1);
    step(0, 1, 0, 0);
    // R7: both buttons
    cnt_h = 0; cnt_m = 0;
    repeat (3) step(0, 1, 1, 1);
    chk_int("R7", "pulses with both pressed", cnt_h + cnt_m, 0);
    step(0, 1, 0, 0);
    // R10: switch minutes straight to hours
    step(0, 1, 0, 1);
    cnt_h = 0;
    step(0, 1, 1, 0);
    chk_int("R10", "hour pulse on switch cycle", cnt_h, 0);
    step(0, 1, 1, 0);
    chk_int("R10", "hour pulse one cycle later", cnt_h, 1);
    // R11: set dropped while holding
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    // R1: reset mid-hold, then the held press counts anew
    step(0, 1, 0, 1);
    step(0, 1, 0, 1);
    step(1, 1, 0, 1);
    step(0, 1, 0, 1);
    step(0, 0, 0, 0);
    // random phase with held patterns
    for (int i = 0; i < 600; i++) begin
      logic r, s, h, m;
      int len;
      r = ($urandom_range(0, 49) == 0);
      s = ($urandom_range(0, 3) != 0);
      h = $urandom_range(0, 1);
      m = $urandom_range(0, 1);
      len = $urandom_range(1, 5);
      for (int k = 0; k < len; k++) step(r, s, h, m);
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule